// File: doc/BRIEF.md
# Reconfigurable Region Bus Dock

This block is a slave on a simple word-wide host bus that connects the host to a region whose logic is swapped at run time. It claims one fixed 16-byte address window. Inside that window the host writes operand words that the dock latches and holds for the region. The host also reads back the region's result word and a status word. Each accepted operand write emits a single-cycle strobe, which the region uses as the clock enable for its own flip-flops. A host write therefore advances the region by exactly one step.

The region can also push results into an internal output FIFO. A block-transfer engine outside the dock drains that FIFO through a valid/ready port. When the FIFO fills, the dock stalls further operand writes until an entry has been drained. It also raises a sticky interrupt, so the host does not have to poll.

Top module: `region_dock`

## Requirements
- R1: An access is claimed only when the address is word aligned (bits 1:0 zero) and bits ADDR_W-1:4 equal those of BASE_ADDR. Any other access gets no acknowledge, no strobe and no state change.
- R2: A write to word offset 0 (address bits 3:2 = 0) stores the data word on `wr_chan`. That value stays unchanged through every other access until the next accepted offset-0 write.
- R3: `wr_stb` is high for exactly one cycle per accepted offset-0 write. It rises in the same cycle as `bus_ack` and as the new `wr_chan` value, and writes to other offsets never raise it.
- R4: Every claimed access is acknowledged by a one-cycle `bus_ack` in the cycle after the request is accepted. A read of offset 0 returns the value of `rd_chan` from the accepting cycle, and reads of offsets 2 and 3 return zero.
- R5: The FIFO stores `res_data` on each cycle in which `res_valid` and `res_ready` are high, with `res_ready` low exactly when it holds DEPTH words. It delivers the words in arrival order on `drn_data`, and `drn_valid` is high while it is not empty.
- R6: A read of offset 1 returns the status word: bit 0 FIFO full, bit 1 FIFO empty, bit 2 interrupt, bits 8 and up the fill count, and all other bits zero.
- R7: While the FIFO is full, an offset-0 write is held without acknowledge and without strobe. It completes after one entry has been drained.
- R8: `irq` rises the cycle after the FIFO becomes full and stays high. A write to offset 1 with bit 0 set lowers it, but only if the FIFO is no longer full; while the FIFO is full such a write leaves it high.
- R9: After reset `wr_chan` is zero, `wr_stb`, `bus_ack` and `irq` are low, the FIFO is empty and `res_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Host request, held until `bus_ack` |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | DATA_W | Read data, valid with `bus_ack` |
| wr_chan | output | DATA_W | Held operand toward the region |
| wr_stb | output | 1 | One-cycle step enable for the region |
| rd_chan | input | DATA_W | Result word from the region |
| res_valid | input | 1 | Region offers a result to the FIFO |
| res_data | input | DATA_W | Result pushed to the FIFO |
| res_ready | output | 1 | FIFO can accept a result |
| drn_valid | output | 1 | FIFO holds a word to drain |
| drn_data | output | DATA_W | Oldest FIFO word |
| drn_ready | input | 1 | Drain side takes the oldest word |
| irq | output | 1 | Sticky FIFO-full interrupt |

## Verification
On every cycle, the assertions check the following:
- the strobe and acknowledge are single cycles;
- the operand only changes together with a strobe;
- no acknowledge follows an out-of-window or stalled request;
- the fill count never exceeds the depth;
- the interrupt holds until cleared.

Only the bench's scenarios can show the following:
- that the correct data words arrive;
- the exact bit layout of the status word;
- first-in first-out order through a full fill and drain;
- that a stalled write completes with its own data once one word leaves the FIFO.

// File: rtl/dock_pkg.sv
package dock_pkg;
   typedef enum logic [1:0] {
      OFF_DATA = 2'd0,
      OFF_CTRL = 2'd1,
      OFF_RSV2 = 2'd2,
      OFF_RSV3 = 2'd3
   } dock_off_e;

   localparam int ST_FULL    = 0;
   localparam int ST_EMPTY   = 1;
   localparam int ST_IRQ     = 2;
   localparam int ST_CNT_LSB = 8;
   localparam int CTRL_CLR   = 0;
endpackage

// File: rtl/dock_decode.sv
module dock_decode
   import dock_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output dock_off_e         off
);
   localparam int WIN_LSB = 4;

   always_comb begin
      hit = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]) &&
            (addr[1:0] == 2'b00);
      off = dock_off_e'(addr[3:2]);
   end
endmodule

// File: rtl/dock_fifo.sv
module dock_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 pdata,
   input  logic                         pop,
   output logic [W-1:0]                 qdata,
   output logic                         full,
   output logic                         empty,
   output logic [$clog2(DEPTH+1)-1:0]   cnt
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam bit   POW2 = ((1 << PTR_W) == DEPTH);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;
   logic             do_push, do_pop;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign qdata   = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign wr_inc = wr_ptr + 1'b1;
         assign rd_inc = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_inc = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         assign rd_inc = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= pdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_inc;
         if (do_pop)  rd_ptr <= rd_inc;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R5: the count can never pass the depth
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   // R5: a push into a full FIFO leaves the count unchanged
   p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> full);
endmodule

// File: rtl/dock_irq.sv
module dock_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= set_i | (irq_o & ~clr_i);
   end

   p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_i) |=> irq_o);
   p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> irq_o);
endmodule

// File: rtl/region_dock.sv
module region_dock
   import dock_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_ack,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] wr_chan,
   output logic              wr_stb,
   input  logic [DATA_W-1:0] rd_chan,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   output logic              res_ready,
   output logic              drn_valid,
   output logic [DATA_W-1:0] drn_data,
   input  logic              drn_ready,
   output logic              irq
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         initial $error("region_dock: DEPTH must be at least 2");
      end
      if (ST_CNT_LSB + CNT_W > DATA_W) begin : g_bad_width
         initial $error("region_dock: fill count does not fit the status word");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         initial $error("region_dock: ADDR_W must exceed the window");
      end
   endgenerate

   logic             hit, full, empty, accept, op_wr, clr;
   dock_off_e        off;
   logic [CNT_W-1:0] cnt;
   logic [DATA_W-1:0] status, rsel;

   dock_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .addr(bus_addr), .hit(hit), .off(off));

   dock_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(res_valid), .pdata(res_data),
      .pop(drn_ready), .qdata(drn_data),
      .full(full), .empty(empty), .cnt(cnt));

   assign res_ready = !full;
   assign drn_valid = !empty;

   assign accept = bus_req && hit && !bus_ack &&
                   !(bus_we && (off == OFF_DATA) && full);
   assign op_wr  = accept && bus_we && (off == OFF_DATA);
   assign clr    = accept && bus_we && (off == OFF_CTRL) && bus_wdata[CTRL_CLR];

   dock_irq u_irq (.clk(clk), .rst_n(rst_n), .set_i(full), .clr_i(clr), .irq_o(irq));

   always_comb begin
      status = '0;
      status[ST_FULL]  = full;
      status[ST_EMPTY] = empty;
      status[ST_IRQ]   = irq;
      status[ST_CNT_LSB +: CNT_W] = cnt;
      case (off)
         OFF_DATA: rsel = rd_chan;
         OFF_CTRL: rsel = status;
         default:  rsel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
         wr_chan   <= '0;
         wr_stb    <= 1'b0;
      end else begin
         bus_ack <= accept;
         wr_stb  <= op_wr;
         if (op_wr) wr_chan <= bus_wdata;
         if (accept && !bus_we) bus_rdata <= rsel;
      end
   end

   // R3: one strobe cycle per write
   p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   // R2: operand changes only with a strobe
   p_wrchan_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wr_chan) |-> wr_stb);
   // R4: acknowledge lasts one cycle
   p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> !bus_ack);
   // R1: nothing answers outside the window
   p_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !hit && !bus_ack) |=> !bus_ack);
   // R7: operand writes stall while full
   p_stall_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && hit && off == OFF_DATA && full && !bus_ack) |=> !wr_stb);
endmodule

// File: tb/region_dock_tb.sv
`timescale 1ns/1ps
module region_dock_tb;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ack;
   logic [31:0] bus_rdata, wr_chan, drn_data;
   logic        wr_stb, res_ready, drn_valid, irq;
   logic [31:0] rd_chan = 32'hC0DE_0001;
   logic        res_valid = 1'b0;
   logic [31:0] res_data = '0;
   logic        drn_ready = 1'b0;

   int n_chk = 0, n_bad = 0, n_stb = 0;

   always #2 clk = ~clk;

   region_dock #(.ADDR_W(16), .DATA_W(32), .DEPTH(DEPTH), .BASE_ADDR(16'h1000)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
      .bus_rdata(bus_rdata), .wr_chan(wr_chan), .wr_stb(wr_stb),
      .rd_chan(rd_chan), .res_valid(res_valid), .res_data(res_data),
      .res_ready(res_ready), .drn_valid(drn_valid), .drn_data(drn_data),
      .drn_ready(drn_ready), .irq(irq));

   always @(negedge clk) if (wr_stb) n_stb++;

   typedef struct packed {
      logic        we;
      logic [15:0] addr;
      logic [31:0] wdata;
      logic        ack;
      logic [31:0] rd;
      logic [31:0] wr;
      logic        stb;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [0:NV-1] = '{
      '{1'b1, 16'h1000, 32'hA5A5_0001, 1'b1, 32'h0,         32'hA5A5_0001, 1'b1},
      '{1'b0, 16'h1000, 32'h0,         1'b1, 32'hC0DE_0001, 32'hA5A5_0001, 1'b0},
      '{1'b1, 16'h2000, 32'h1111_1111, 1'b0, 32'h0,         32'hA5A5_0001, 1'b0},
      '{1'b1, 16'h1010, 32'h2222_2222, 1'b0, 32'h0,         32'hA5A5_0001, 1'b0},
      '{1'b1, 16'h1001, 32'h3333_3333, 1'b0, 32'h0,         32'hA5A5_0001, 1'b0},
      '{1'b1, 16'h1004, 32'h0,         1'b1, 32'h0,         32'hA5A5_0001, 1'b0},
      '{1'b0, 16'h1004, 32'h0,         1'b1, 32'h0000_0002, 32'hA5A5_0001, 1'b0},
      '{1'b1, 16'h100C, 32'h4444_4444, 1'b1, 32'h0,         32'hA5A5_0001, 1'b0},
      '{1'b0, 16'h1008, 32'h0,         1'b1, 32'h0,         32'hA5A5_0001, 1'b0},
      '{1'b1, 16'h1000, 32'h5A5A_0002, 1'b1, 32'h0,         32'h5A5A_0002, 1'b1},
      '{1'b0, 16'h0FFC, 32'h0,         1'b0, 32'h0,         32'h5A5A_0002, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus(input logic we, input logic [15:0] a, input logic [31:0] d,
                      output logic got, output logic [31:0] rd);
      got = 1'b0;
      rd  = '0;
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
      for (int k = 0; k < 6 && !got; k++) begin
         @(negedge clk);
         if (bus_ack) begin got = 1'b1; rd = bus_rdata; end
      end
      bus_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic        got;
      logic [31:0] rd;
      int          s0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 wr_chan", wr_chan, 32'h0);
      chk("R9 flags {stb,ack,irq,drn_valid,res_ready}",
          {27'h0, wr_stb, bus_ack, irq, drn_valid, res_ready}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);

      // table: R1 window, R2 hold, R3 strobe, R4 read, R6 empty status
      for (int i = 0; i < NV; i++) begin
         s0 = n_stb;
         bus(VEC[i].we, VEC[i].addr, VEC[i].wdata, got, rd);
         @(negedge clk);
         chk($sformatf("R1/R4 ack v%0d", i), {31'h0, got}, {31'h0, VEC[i].ack});
         if (VEC[i].ack && !VEC[i].we)
            chk($sformatf("R4/R6 rdata v%0d", i), rd, VEC[i].rd);
         chk($sformatf("R2 wr_chan v%0d", i), wr_chan, VEC[i].wr);
         chk($sformatf("R3 strobes v%0d", i), n_stb - s0, {31'h0, VEC[i].stb});
      end

      // R5 fill the FIFO
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         res_valid = 1'b1; res_data = 32'd100 + i;
      end
      @(negedge clk);
      res_valid = 1'b0;
      chk("R5 res_ready low when full", {31'h0, res_ready}, 32'h0);
      @(negedge clk);
      chk("R8 irq on full", {31'h0, irq}, 32'h1);
      bus(1'b0, 16'h1004, 32'h0, got, rd);
      chk("R6 status full", rd, 32'h0000_1005);

      // R8 clear while full has no effect
      bus(1'b1, 16'h1004, 32'h1, got, rd);
      @(negedge clk);
      chk("R8 irq held while full", {31'h0, irq}, 32'h1);

      // R7 stalled write
      s0 = n_stb;
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = 16'h1000; bus_wdata = 32'hCAFE_0003;
      got = 1'b0;
      repeat (4) begin
         @(negedge clk);
         if (bus_ack) got = 1'b1;
      end
      chk("R7 no ack while full", {31'h0, got}, 32'h0);
      chk("R7 no strobe while full", n_stb - s0, 32'h0);
      chk("R5 first out", drn_data, 32'd100);
      drn_ready = 1'b1;
      @(negedge clk);
      drn_ready = 1'b0;
      for (int k = 0; k < 4 && !got; k++) begin
         @(negedge clk);
         if (bus_ack) got = 1'b1;
      end
      bus_req = 1'b0;
      @(negedge clk);
      chk("R7 write completes after drain", {31'h0, got}, 32'h1);
      chk("R7 operand after stall", wr_chan, 32'hCAFE_0003);
      chk("R3 one strobe after stall", n_stb - s0, 32'h1);
      chk("R8 irq still set", {31'h0, irq}, 32'h1);

      // R8 clear when not full
      bus(1'b1, 16'h1004, 32'h1, got, rd);
      @(negedge clk);
      chk("R8 irq cleared", {31'h0, irq}, 32'h0);
      bus(1'b0, 16'h1004, 32'h0, got, rd);
      chk("R6 status count 15", rd, 32'h0000_0F00);

      // R5 drain order
      for (int i = 1; i < DEPTH; i++) begin
         @(negedge clk);
         chk($sformatf("R5 order %0d", i), drn_data, 32'd100 + i);
         drn_ready = 1'b1;
      end
      @(negedge clk);
      drn_ready = 1'b0;
      chk("R5 drn_valid low when empty", {31'h0, drn_valid}, 32'h0);
      bus(1'b0, 16'h1004, 32'h0, got, rd);
      chk("R6 status empty", rd, 32'h0000_0002);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule